// File: doc/BRIEF.md
# Two-Wire Bus Serial-Clock Prescaler

This block derives the serial-clock timing of a two-wire bus master from a fast system clock. A one-byte rate setting holds two factors: a linear factor M and an exponential factor N. A first divider produces a pulse every 2^(N+1) system cycles. A second divider counts M+1 of those pulses to form one step. Ten steps make one serial-clock period: five steps low, then five steps high. The bus rate is therefore the system clock divided by 10·(M+1)·2^(N+1).

The byte engine that drives the bus uses a strobe that fires once in the middle of each low half, where it may change the data line, and once in the middle of each high half, where it samples the data line. A free-running serial-clock reference is also output for test. A new rate takes effect only at the start of the next low half, so no shortened pulse appears. A hold input, raised while a slave stretches the clock low, freezes the step counter.

Top module: `sclk_prescaler`

## Requirements
- R1: A write places bits [2:0] of the written byte in the N field and bits [6:3] in the M field. The read port returns M in bits [6:3] and N in bits [2:0].
- R2: While the rate is steady and hold is low, the reference clock has a period of exactly 10·(M+1)·2^(N+1) system cycles. This holds for every N from 0 to 7 and every M from 0 to 15.
- R3: Bit 7 of a written byte is ignored. Bit 7 of the read port is always 0.
- R4: Each period is low for 5·(M+1)·2^(N+1) cycles and then high for the same number of cycles. The low half starts each period.
- R5: The strobe `qtick` is high for exactly one cycle at 2·T cycles after the low half starts, where T = (M+1)·2^(N+1). At that pulse `qtick_hi` is 0. The strobe never pulses in the same cycle as an edge of the reference clock.
- R6: The strobe also pulses at 7·T cycles after the low half starts, with `qtick_hi` at 1. There are exactly two pulses per period.
- R7: A written rate does not change the period that is running. Both dividers restart from zero with the new rate at the next falling edge of the reference clock.
- R8: While `scl_hold` is high, the reference clock and the step counter do not move and `qtick` stays low. A hold that starts at the start of the low half and lasts H cycles, with H a multiple of 2^(N+1), delays the next rising edge by exactly H cycles.
- R9: After reset the rate byte reads 0x62 (M=12, N=2), which gives about 96 kHz from a 100 MHz clock. The reference clock is low, and `qtick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Rate byte write strobe |
| cfg_wdata | input | 8 | Rate byte to write |
| cfg_rdata | output | 8 | Current rate byte |
| scl_hold | input | 1 | Freezes the step counter while the clock is stretched |
| qtick | output | 1 | Mid-low / mid-high strobe |
| qtick_hi | output | 1 | The strobe marks the mid-high sample point |
| scl_ref | output | 1 | Free-running serial-clock reference |

## Verification
The bench builds the block with its default parameters. These are a 3-bit N field, a 4-bit M field, five steps per half period and a reset rate of M=12, N=2. With these values both field extremes can be reached. N=7 drives the 9-bit first divider to its top count, and M=15 drives the second divider to its full range. The bench also exercises a write with bit 7 set, and a rate change made in the middle of a high half. Finally it applies a hold whose length is a multiple of the first-divider period, so the stretched low half has an exact expected length.

// File: rtl/sclp_pkg.sv
package sclp_pkg;
  localparam int unsigned N_W    = 3;
  localparam int unsigned M_W    = 4;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned RATE_W = M_W + N_W;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [N_W-1:0] n;
  } rate_t;

  function automatic rate_t unpack_cfg(input logic [CFG_W-1:0] b);
    rate_t r;
    r.n = b[N_W-1:0];
    r.m = b[N_W+M_W-1:N_W];
    return r;
  endfunction
endpackage

// File: rtl/sclp_cfg.sv
module sclp_cfg
  import sclp_pkg::*;
#(
  parameter int unsigned DEF_M = 12,
  parameter int unsigned DEF_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             boundary,
  output logic [CFG_W-1:0] rd_data,
  output rate_t            act,
  output logic             restart
);
  localparam rate_t DEF_RATE = '{m: M_W'(DEF_M), n: N_W'(DEF_N)};

  rate_t cfg_q, cfg_d, act_q, act_d;
  logic  pend_q, pend_d;

  always_comb begin
    restart = boundary & pend_q;
    cfg_d   = wr_en ? unpack_cfg(wr_data) : cfg_q;
    pend_d  = wr_en | (pend_q & ~boundary);
    act_d   = restart ? cfg_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= DEF_RATE;
      act_q  <= DEF_RATE;
      pend_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign rd_data = {{(CFG_W - RATE_W){1'b0}}, cfg_q};
  assign act     = act_q;
endmodule

// File: rtl/sclp_prediv.sv
module sclp_prediv
  import sclp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n,
  input  logic           restart,
  output logic           tc
);
  localparam int unsigned CW   = (1 << N_W) + 1;
  localparam int unsigned SH_W = N_W + 1;

  logic [CW-1:0]   cnt_q, cnt_d, lim;
  logic [SH_W-1:0] shamt;

  always_comb begin
    shamt = {1'b0, n} + SH_W'(1);
    lim   = (CW'(1) << shamt) - CW'(1);
    tc    = (cnt_q == lim);
    cnt_d = (restart || tc) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sclp_ratediv.sv
module sclp_ratediv
  import sclp_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           hold,
  input  logic           restart,
  input  logic [M_W-1:0] m,
  output logic           step
);
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           adv;

  always_comb begin
    adv   = en & ~hold;
    step  = adv & (cnt_q == m);
    cnt_d = cnt_q;
    if (restart || step) cnt_d = '0;
    else if (adv)        cnt_d = cnt_q + M_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sclp_phase.sv
module sclp_phase #(
  parameter int unsigned HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic boundary,
  output logic scl,
  output logic qtick
);
  localparam int unsigned STEPS = 2 * HALF;
  localparam int unsigned PH_W  = $clog2(STEPS);
  localparam int unsigned LAST  = STEPS - 1;
  localparam int unsigned MIDL  = HALF / 2;
  localparam int unsigned MIDH  = HALF + HALF / 2;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            qt_q, qt_d;

  always_comb begin
    boundary = step & (ph_q == PH_W'(LAST));
    ph_d     = ph_q;
    if (step) ph_d = boundary ? '0 : ph_q + PH_W'(1);
    qt_d     = step & ((ph_q == PH_W'(MIDL - 1)) || (ph_q == PH_W'(MIDH - 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      qt_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      qt_q <= qt_d;
    end
  end

  assign scl   = (ph_q >= PH_W'(HALF));
  assign qtick = qt_q;
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclp_pkg::*;
#(
  parameter int unsigned DEF_M = 12,
  parameter int unsigned DEF_N = 2,
  parameter int unsigned HALF  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             scl_hold,
  output logic             qtick,
  output logic             qtick_hi,
  output logic             scl_ref
);
  rate_t act;
  logic  restart, boundary, pre_tc, step;

  sclp_cfg #(.DEF_M(DEF_M), .DEF_N(DEF_N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .boundary(boundary), .rd_data(cfg_rdata), .act(act), .restart(restart)
  );

  sclp_prediv u_pre (
    .clk(clk), .rst_n(rst_n), .n(act.n), .restart(restart), .tc(pre_tc)
  );

  sclp_ratediv u_rate (
    .clk(clk), .rst_n(rst_n), .en(pre_tc), .hold(scl_hold),
    .restart(restart), .m(act.m), .step(step)
  );

  sclp_phase #(.HALF(HALF)) u_ph (
    .clk(clk), .rst_n(rst_n), .step(step), .boundary(boundary),
    .scl(scl_ref), .qtick(qtick)
  );

  assign qtick_hi = qtick & scl_ref;
endmodule

// File: rtl/sclp_checker.sv
module sclp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_hold,
  input logic       qtick,
  input logic       scl_ref,
  input logic [7:0] cfg_rdata
);
  assert_rd_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[7] == 1'b0);

  assert_hold_freezes_scl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |=> $stable(scl_ref));

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |=> !qtick);

  assert_tick_off_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |-> $stable(scl_ref));

  assert_tick_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    qtick |=> !qtick);
endmodule

bind sclk_prescaler sclp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_hold(scl_hold), .qtick(qtick),
  .scl_ref(scl_ref), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_sclk_prescaler.sv
module sim_sclk_prescaler;
  logic       clk, rst_n, cfg_we, scl_hold;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       qtick, qtick_hi, scl_ref;
  int         cyc, n_chk, n_fail;
  bit         done;

  sclk_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .scl_hold(scl_hold), .qtick(qtick),
    .qtick_hi(qtick_hi), .scl_ref(scl_ref)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {written byte, expected read-back}
  localparam logic [15:0] VEC [6] = '{
    16'h00_00, 16'h89_09, 16'h07_07, 16'h78_78, 16'hFC_7C, 16'h2B_2B
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unit_of(input logic [7:0] rd);
    return (int'(rd[6:3]) + 1) * (1 << (int'(rd[2:0]) + 1));
  endfunction

  task automatic wr(input logic [7:0] b);
    cfg_wdata = b; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_fall();
    while (scl_ref == 1'b0) @(negedge clk);
    while (scl_ref == 1'b1) @(negedge clk);
  endtask

  // Called at the first sample where scl_ref is low; runs one period.
  task automatic measure(input int t);
    int t0 = cyc, lo = -1, hi = -1, qlo = -1, qhi = -1, nq = 0;
    bit seen_hi = 1'b0;
    bit fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      if (qtick) begin
        nq++;
        if (qtick_hi) qhi = cyc - t0; else qlo = cyc - t0;
      end
      if (!seen_hi && scl_ref) begin
        seen_hi = 1'b1; lo = cyc - t0;
      end else if (seen_hi && !scl_ref) begin
        hi = cyc - t0 - lo; fin = 1'b1;
      end
    end
    chk("R4 low half", lo, 5 * t);
    chk("R4 high half", hi, 5 * t);
    chk("R2 period", lo + hi, 10 * t);
    chk("R5 mid-low strobe", qlo, 2 * t);
    chk("R6 mid-high strobe", qhi, 7 * t);
    chk("R6 strobes per period", nq, 2);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc = 0; n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; scl_hold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset scl_ref", int'(scl_ref), 0);
    chk("R9 reset qtick", int'(qtick), 0);
    chk("R9 reset rate byte", int'(cfg_rdata), 'h62);
    rst_n = 1'b1;
    wait_fall();
    measure(104); // R9 default rate, T = 13*8

    // Table walk: R1 field decode, R3 top bit dropped, R2 all extremes
    foreach (VEC[i]) begin
      wr(VEC[i][15:8]);
      chk("R1 R3 read-back", int'(cfg_rdata), int'(VEC[i][7:0]));
      wait_fall();
      measure(unit_of(VEC[i][7:0]));
    end

    // R8: hold from start of low half, length a multiple of 2^(N+1)
    begin
      int t = unit_of(8'h2B);
      int ht = 8 * t;
      int t0, nq = 0, nhi = 0;
      wait_fall();
      t0 = cyc;
      scl_hold = 1'b1;
      for (int k = 0; k < ht; k++) begin
        @(negedge clk);
        if (qtick) nq++;
        if (scl_ref) nhi++;
      end
      scl_hold = 1'b0;
      chk("R8 no strobe during hold", nq, 0);
      chk("R8 scl frozen low", nhi, 0);
      while (!scl_ref) @(negedge clk);
      chk("R8 stretched low length", cyc - t0, ht + 5 * t);
    end

    // R7: a rate written mid-high leaves the running period alone
    begin
      int ta = unit_of(8'h2B);
      int t0;
      wait_fall();
      t0 = cyc;
      repeat (6 * ta) @(negedge clk);
      wr(8'h11);
      wait_fall();
      chk("R7 old period completes", cyc - t0, 10 * ta);
      measure(unit_of(8'h11)); // R7 new rate from the boundary
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule